// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets an external master read and write a small internal register file over a three-line serial link. The master supplies a serial clock, a data input and an active-high chip enable. The block returns read data on a serial output. It also provides an output-enable, so the data input and data output can be joined into one bidirectional wire. All pins are synchronised into the system clock domain. Rising and falling edges of the serial clock are detected there.

Each frame is bounded by a high period of the chip enable. The first byte of a frame is a command byte:

- Bit 7 selects the direction: 1 is read, 0 is write.
- Bits 6:4 carry a device subaddress, which must equal 3'b001.
- Bits 3:0 give the start register.

Any number of data bytes follow, and the register address advances after each one. Toward the register file, the block drives a parallel port:

- an address;
- write data with a one-cycle write strobe;
- a one-cycle read strobe, during which the file returns the byte on `reg_rdata`.

Top module: `spi3_reg_slave`

## Requirements
- R1: After reset, and whenever the chip enable is low, `spi_sdo_oe`, `reg_we` and `reg_re` are all low.
- R2: Chip enable going low aborts the frame at once. A partly received byte is dropped and no register is written. The next high period starts again with a command byte.
- R3: `spi_sdi` is sampled on rising edges of `spi_scl`, and bytes are assembled most significant bit first.
- R4: While `spi_sdo_oe` is high, `spi_sdo` changes only after a falling edge of `spi_scl`. The most significant bit of each read byte is presented after the falling edge that follows the last rising edge of the previous byte.
- R5: In the command byte, bit 7 = 1 means read and 0 means write, bits 6:4 must equal 3'b001, and bits 3:0 are the start register address.
- R6: When the subaddress field differs from 3'b001, the rest of the frame is ignored: no write strobe, no read strobe, and `spi_sdo_oe` stays low.
- R7: In a write frame, each complete data byte produces exactly one one-cycle `reg_we` pulse, carrying the assembled byte on `reg_wdata` and the current address on `reg_addr`.
- R8: The register address increments by one after each complete data byte, wrapping from 15 to 0.
- R9: In a read frame, `reg_re` pulses for one cycle with the address to read before the first falling edge of each data byte. `reg_rdata` is taken in that cycle and shifted out MSB first.
- R10: `spi_sdo_oe` is high only during the data phase of a read frame. It stays low during the command byte and through write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_scl | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data from the master |
| spi_ce | input | 1 | Active-high chip enable framing each transaction |
| spi_sdo | output | 1 | Serial read data (0 while released) |
| spi_sdo_oe | output | 1 | Drive enable for the serial output |
| reg_addr | output | 4 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register file read data, valid while `reg_re` is high |

## Verification
Write bursts with mixed bit patterns (0xA5, 0x3C, 0xF0) expose bit-order and byte-alignment faults. A burst that starts at register 14 separates correct address wrapping from overflow into a wrong register. Read bursts compare the serial bytes against a shadow of all writes, which shows whether each fetch happens before the first falling edge. A frame with a wrong subaddress, and frames cut short inside the command and inside a data byte, show that ignored or partial traffic never reaches the register file and never drives the line.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } spi3_phase_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi3_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_async;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi3_rx_shift.sv
module spi3_rx_shift #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            shift_en,
   input  logic            din,
   output logic [BITS-1:0] data_o,
   output logic            done
);
   localparam int CNT_W = $clog2(BITS);

   logic [BITS-1:0]  sr_q;
   logic [CNT_W-1:0] cnt_q;

   assign data_o = {sr_q[BITS-2:0], din};
   assign done   = shift_en && (cnt_q == CNT_W'(BITS-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sr_q  <= data_o;
         cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
   end

   // R3
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cnt_q == '0));

   // R2
   clear_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));
endmodule

// File: rtl/spi3_tx_shift.sv
module spi3_tx_shift #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            load,
   input  logic [BITS-1:0] load_val,
   input  logic            shift_en,
   output logic            bit_o
);
   logic [BITS-1:0] sr_q;
   logic            bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         bit_q <= 1'b0;
      end else if (clear) begin
         sr_q  <= '0;
         bit_q <= 1'b0;
      end else if (load) begin
         sr_q  <= load_val;
      end else if (shift_en) begin
         bit_q <= sr_q[BITS-1];
         sr_q  <= {sr_q[BITS-2:0], 1'b0};
      end
   end

   assign bit_o = bit_q;

   // R4
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !clear) |=> $stable(bit_q));
endmodule

// File: rtl/spi3_reg_slave.sv
module spi3_reg_slave
   import spi3_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         ADDR_W      = 4,
   parameter int         SUB_W       = 3,
   parameter logic [2:0] SUB_ID      = 3'b001,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_scl,
   input  logic              spi_sdi,
   input  logic              spi_ce,
   output logic              spi_sdo,
   output logic              spi_sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);
   localparam int CMD_RD_BIT  = DATA_W - 1;
   localparam int CMD_SUB_TOP = DATA_W - 2;

   generate
      if (DATA_W != 1 + SUB_W + ADDR_W) begin : g_bad_cmd
         $error("command byte must hold direction, subaddress and address");
      end
      if (SUB_W != 3) begin : g_bad_sub
         $error("subaddress field is three bits wide");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       ce_s, sdi_s, scl_s, scl_prev_q;
   logic       scl_rise, scl_fall;

   spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({spi_ce, spi_sdi, spi_scl}),
      .q       (pins_s)
   );

   assign ce_s  = pins_s[2];
   assign sdi_s = pins_s[1];
   assign scl_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev_q <= 1'b0;
      else        scl_prev_q <= scl_s;
   end

   assign scl_rise = ce_s && scl_s && !scl_prev_q;
   assign scl_fall = ce_s && !scl_s && scl_prev_q;

   spi3_phase_t       phase_q;
   logic              is_rd_q, fetch_q, we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rx_byte;
   logic              rx_done, rx_shift, frame_clr;

   assign frame_clr = !ce_s;
   assign rx_shift  = scl_rise && ((phase_q == PH_CMD) || (phase_q == PH_DATA));

   spi3_rx_shift #(.BITS(DATA_W)) i_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (frame_clr),
      .shift_en (rx_shift),
      .din      (sdi_s),
      .data_o   (rx_byte),
      .done     (rx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         is_rd_q <= 1'b0;
         fetch_q <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         fetch_q <= 1'b0;
         we_q    <= 1'b0;
         if (!ce_s) begin
            phase_q <= PH_IDLE;
            is_rd_q <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_IDLE: phase_q <= PH_CMD;
               PH_CMD: begin
                  if (rx_done) begin
                     if (rx_byte[CMD_SUB_TOP -: SUB_W] == SUB_ID) begin
                        phase_q <= PH_DATA;
                        is_rd_q <= rx_byte[CMD_RD_BIT];
                        fetch_q <= rx_byte[CMD_RD_BIT];
                        addr_q  <= rx_byte[ADDR_W-1:0];
                     end else begin
                        phase_q <= PH_SKIP;
                     end
                  end
               end
               PH_DATA: begin
                  if (rx_done) begin
                     if (is_rd_q) begin
                        addr_q  <= addr_q + 1'b1;
                        fetch_q <= 1'b1;
                     end else begin
                        we_q    <= 1'b1;
                        wdata_q <= rx_byte;
                     end
                  end
                  if (we_q) addr_q <= addr_q + 1'b1;
               end
               default: phase_q <= PH_SKIP;
            endcase
         end
      end
   end

   logic tx_bit, tx_shift;

   assign tx_shift = scl_fall && (phase_q == PH_DATA) && is_rd_q;

   spi3_tx_shift #(.BITS(DATA_W)) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (frame_clr),
      .load     (fetch_q),
      .load_val (reg_rdata),
      .shift_en (tx_shift),
      .bit_o    (tx_bit)
   );

   assign spi_sdo_oe = ce_s && (phase_q == PH_DATA) && is_rd_q;
   assign spi_sdo    = spi_sdo_oe && tx_bit;
   assign reg_addr   = addr_q;
   assign reg_wdata  = wdata_q;
   assign reg_we     = we_q;
   assign reg_re     = fetch_q;

   // R7
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R9
   re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));

   // R2
   ce_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> (phase_q == PH_IDLE) && !spi_sdo_oe);

   // R6
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SKIP) |-> (!reg_we && !spi_sdo_oe));

   // R4
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(spi_sdo_oe) && spi_sdo_oe && !$past(scl_fall)) |-> $stable(spi_sdo));

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && ce_s && (phase_q == PH_DATA)) |=> (reg_addr == $past(reg_addr) + 1'b1));
endmodule

// File: tb/test_spi3_reg_slave.sv
module test_spi3_reg_slave;
   localparam int HALF = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b0, sdi = 1'b0, ce = 1'b0;
   logic       sdo, sdo_oe, reg_we, reg_re;
   logic [3:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] mem    [16];
   logic [7:0] shadow [16];
   logic [11:0] exp_q [$];
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spi3_reg_slave i_spi3_reg_slave (
      .clk(clk), .rst_n(rst_n), .spi_scl(scl), .spi_sdi(sdi), .spi_ce(ce),
      .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
      .reg_rdata(reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   initial for (int i = 0; i < 16; i++) mem[i] = 8'h00;
   always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected write strobes (R7, R8)
   always @(negedge clk) begin
      if (reg_we) begin
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected write strobe", {reg_addr, reg_wdata}, 0);
         else begin
            logic [11:0] e;
            e = exp_q.pop_front();
            chk({reg_addr, reg_wdata} == e, "R7/R8 write addr+data", {reg_addr, reg_wdata}, e);
         end
         chk(!reg_re, "R7 strobes exclusive", reg_re, 0);
      end
   end

   task automatic ticks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
      for (int i = 7; i > 7 - nbits; i--) begin
         sdi = tx[i];
         ticks(HALF);
         rx[i] = sdo;
         scl = 1'b1;
         ticks(HALF - 1);
         if (sdo_oe) chk(sdo == rx[i], "R4 sdo held across high phase", sdo, rx[i]);
         scl = 1'b0;
      end
   endtask

   task automatic frame_begin();
      ce = 1'b1;
      ticks(6);
   endtask

   task automatic frame_end();
      ticks(HALF);
      ce = 1'b0;
      ticks(8);
      chk(!sdo_oe && !reg_we && !reg_re, "R1 idle after CE low", sdo_oe, 0);
   endtask

   task automatic wr_burst(input logic [3:0] start, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n);
      logic [7:0] rx;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      frame_begin();
      xfer({4'b0001, start}, rx);
      for (int k = 0; k < n; k++) begin
         logic [3:0] a;
         a = start + 4'(k);
         exp_q.push_back({a, d[k]});
         shadow[a] = d[k];
         xfer(d[k], rx);
         chk(!sdo_oe, "R10 oe low in write frame", sdo_oe, 0);
      end
      frame_end();
   endtask

   task automatic rd_burst(input logic [3:0] start, input int n);
      logic [7:0] rx;
      frame_begin();
      chk(!sdo_oe, "R10 oe low before command", sdo_oe, 0);
      xfer({4'b1001, start}, rx);
      ticks(2);
      chk(sdo_oe, "R10 oe high in read data phase", sdo_oe, 1);
      for (int k = 0; k < n; k++) begin
         logic [3:0] a;
         a = start + 4'(k);
         xfer(8'h00, rx);
         chk(rx == shadow[a], "R9/R3/R8 read byte", rx, shadow[a]);
      end
      frame_end();
   endtask

   initial begin
      logic [7:0] rx;
      for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
      ticks(5);
      chk(!sdo_oe && !reg_we && !reg_re, "R1 reset state", {sdo_oe, reg_we, reg_re}, 0);
      rst_n = 1'b1;
      ticks(5);
      chk(!sdo_oe && !reg_we && !reg_re, "R1 idle after reset", {sdo_oe, reg_we, reg_re}, 0);

      // R3 R5 R7: write burst, mixed patterns
      wr_burst(4'h2, 8'hA5, 8'h3C, 8'hF0, 3);
      // R8: wrap from 15 to 0
      wr_burst(4'hE, 8'h11, 8'h22, 8'h33, 3);
      // R9: read back, including wrap
      rd_burst(4'h2, 3);
      rd_burst(4'hF, 2);

      // R6: wrong subaddress write, then wrong subaddress read
      frame_begin();
      xfer(8'b0000_0010, rx);
      xfer(8'h77, rx);
      chk(!sdo_oe, "R6 oe low after bad write cmd", sdo_oe, 0);
      frame_end();
      frame_begin();
      xfer(8'b1010_0010, rx);
      xfer(8'h00, rx);
      chk(!sdo_oe, "R6 oe low after bad read cmd", sdo_oe, 0);
      frame_end();
      rd_burst(4'h2, 1);

      // R2: partial data byte discarded
      frame_begin();
      xfer(8'b0001_0101, rx);
      xfer(8'hFF, rx, 4);
      frame_end();
      rd_burst(4'h5, 1);

      // R2: partial command, next frame starts with a fresh command
      frame_begin();
      xfer(8'b1001_0000, rx, 5);
      frame_end();
      wr_burst(4'h7, 8'h5A, 8'h00, 8'h00, 1);
      rd_burst(4'h7, 1);

      ticks(20);
      chk(exp_q.size() == 0, "R7 all expected strobes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule